// File: doc/BRIEF.md
# Masked Interrupt Event Distributor

This block keeps the interrupt cause register and the interrupt enable mask of a network controller and drives thirteen separate, active-high interrupt lines from them. Each line follows exactly one cause bit, gated by the enable bit at the same position. Cause bits are set by one-cycle pulses from the controller's datapath, and by two side effects of register writes: any write to the management frame register, and a write of the transmit control register with its stop request bit set. Software acknowledges causes by writing ones to the cause register.

The register port is a simple single-cycle write strobe with a two-bit word address and a combinational read-data output. The cause generators themselves sit outside this block. Each line is a registered output. It changes one cycle after the masked cause state changes and holds its value otherwise.

Top module: `irq_event_distributor`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets the cause bit given by this line-to-bit table: line 0→27, 1→26, 2→19, 3→20, 4→25, 5→24, 6→23, 7→21, 8→31, 9→28, 10→22, 11→29, 12→30. Bits 18:0 of the cause register have no source and always read 0.
- R2: `irq_line[i]` equals (cause AND mask) at the bit that line i maps to in R1, as held by the registers one clock earlier. A line changes only when that masked bit changes.
- R3: A write to address 0 clears every cause bit whose written bit is 1. Bits written as 0 keep their value. A read of address 0 returns the cause register.
- R4: A write to address 1 replaces all 32 mask bits with the written value. A read of address 1 returns the mask.
- R5: Any write to address 2, the management frame register, sets cause bit 23, whatever the data.
- R6: A write to address 3, the transmit control register, with data bit 0 set sets cause bit 28. With data bit 0 clear it sets nothing.
- R7: When a set, from a pulse or a write side effect, and a clearing write hit the same cause bit in the same cycle, the bit ends up set.
- R8: While `rst_n` is low, the cause and mask registers and all lines are 0.
- R9: Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 13 | One-cycle set pulses, indexed by line number |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 cause, 1 mask, 2 management frame, 3 transmit control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_line | output | 13 | Registered interrupt lines |

## Verification
A cause bit that is lost, or that sticks after an acknowledge, shows up on the read port in the cycle after the write. When its enable is set, the mapped line also goes wrong one cycle after that. A wrong entry in the line map shows only once the cause is enabled: the wrong line rises, or the right line stays low, two clock edges after the pulse. The random mix of pulses, acknowledges and mask rewrites therefore compares both the readback and every line after each single cycle, so a fault surfaces within two cycles of its cause.

// File: rtl/ied_pkg.sv
package ied_pkg;
   localparam int unsigned EVT_W   = 32;
   localparam int unsigned N_LINES = 13;
   localparam int unsigned ADDR_W  = 2;

   localparam logic [ADDR_W-1:0] A_CAUSE = 2'd0;
   localparam logic [ADDR_W-1:0] A_MASK  = 2'd1;
   localparam logic [ADDR_W-1:0] A_MGMT  = 2'd2;
   localparam logic [ADDR_W-1:0] A_TXCTL = 2'd3;

   localparam int unsigned BIT_MGMT_DONE = 23;
   localparam int unsigned BIT_STOP_DONE = 28;

   // cause bit that drives each output line
   function automatic int unsigned line_src(input int unsigned ln);
      case (ln)
         0:       return 27;
         1:       return 26;
         2:       return 19;
         3:       return 20;
         4:       return 25;
         5:       return 24;
         6:       return 23;
         7:       return 21;
         8:       return 31;
         9:       return 28;
         10:      return 22;
         11:      return 29;
         default: return 30;
      endcase
   endfunction

   function automatic logic [N_LINES-1:0] gather(input logic [EVT_W-1:0] v);
      logic [N_LINES-1:0] r;
      for (int unsigned ln = 0; ln < N_LINES; ln++) r[ln] = v[line_src(ln)];
      return r;
   endfunction
endpackage

// File: rtl/ied_cause_bank.sv
module ied_cause_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] cause_q
);
   // set has priority over clear (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/ied_mask_bank.sv
module ied_mask_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (load) mask_q <= din;
   end
endmodule

// File: rtl/ied_line_drive.sv
module ied_line_drive #(
   parameter int unsigned W = 32,
   parameter int unsigned N = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] active,
   output logic [N-1:0] line_q
);
   for (genvar g = 0; g < N; g++) begin : g_line
      localparam int unsigned SRC = ied_pkg::line_src(g);
      logic hit;
      assign hit = active[SRC];
      // update only on a change of the recorded masked state
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              line_q[g] <= 1'b0;
         else if (hit != line_q[g]) line_q[g] <= hit;
      end
   end
endmodule

// File: rtl/irq_event_distributor.sv
module irq_event_distributor #(
   parameter int unsigned EVT_W   = 32,
   parameter int unsigned N_LINES = 13,
   parameter int unsigned ADDR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LINES-1:0] evt_pulse,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [EVT_W-1:0]  reg_wdata,
   output logic [EVT_W-1:0]  reg_rdata,
   output logic [N_LINES-1:0] irq_line
);
   import ied_pkg::*;

   if (EVT_W != ied_pkg::EVT_W) begin : g_bad_width
      $error("EVT_W must match the fixed cause bit layout");
   end
   if (N_LINES != ied_pkg::N_LINES) begin : g_bad_lines
      $error("N_LINES must match the fixed line map");
   end
   if (ADDR_W != ied_pkg::ADDR_W) begin : g_bad_addr
      $error("ADDR_W must match the register decode");
   end

   logic [EVT_W-1:0] set_vec, clr_vec, cause_q, mask_q, active;
   logic wr_cause, wr_mask, wr_mgmt, wr_txctl;

   assign wr_cause = reg_wr && (reg_addr == A_CAUSE);
   assign wr_mask  = reg_wr && (reg_addr == A_MASK);
   assign wr_mgmt  = reg_wr && (reg_addr == A_MGMT);
   assign wr_txctl = reg_wr && (reg_addr == A_TXCTL);

   always_comb begin
      set_vec = '0;
      for (int unsigned ln = 0; ln < N_LINES; ln++)
         set_vec[line_src(ln)] = evt_pulse[ln];
      if (wr_mgmt)                 set_vec[BIT_MGMT_DONE] = 1'b1;
      if (wr_txctl && reg_wdata[0]) set_vec[BIT_STOP_DONE] = 1'b1;
   end

   assign clr_vec = wr_cause ? reg_wdata : '0;

   ied_cause_bank #(.W(EVT_W)) u_cause (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .cause_q(cause_q)
   );

   ied_mask_bank #(.W(EVT_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .load(wr_mask), .din(reg_wdata), .mask_q(mask_q)
   );

   assign active = cause_q & mask_q;

   ied_line_drive #(.W(EVT_W), .N(N_LINES)) u_lines (
      .clk(clk), .rst_n(rst_n), .active(active), .line_q(irq_line)
   );

   always_comb begin
      case (reg_addr)
         A_CAUSE: reg_rdata = cause_q;
         A_MASK:  reg_rdata = mask_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ied_checker.sv
module ied_checker (
   input logic        clk,
   input logic        rst_n,
   input logic [12:0] evt_pulse,
   input logic        reg_wr,
   input logic [1:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic [31:0] cause_q,
   input logic [31:0] mask_q,
   input logic [12:0] irq_line
);
   import ied_pkg::*;

   AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((gather(cause_q) & $past(evt_pulse)) == $past(evt_pulse))); // R1
   AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_line == gather($past(cause_q & mask_q)))); // R2
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CAUSE && evt_pulse == '0) |=> ((cause_q & $past(reg_wdata)) == '0)); // R3
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_MASK) |=> (mask_q == $past(reg_wdata))); // R4
   AST_MGMT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_MGMT) |=> cause_q[BIT_MGMT_DONE]); // R5
   AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_TXCTL && reg_wdata[0]) |=> cause_q[BIT_STOP_DONE]); // R6
   AST_NO_SOURCE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cause_q[18:0] == '0)); // R1
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (cause_q == '0 && mask_q == '0 && irq_line == '0)); // R8
endmodule

bind irq_event_distributor ied_checker u_chk (
   .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cause_q(cause_q),
   .mask_q(mask_q), .irq_line(irq_line)
);

// File: tb/irq_event_distributor_bench.sv
`timescale 1ns/1ps
module irq_event_distributor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] evt_pulse = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [12:0] irq_line;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [31:0] cause_m = '0;
   logic [31:0] mask_m = '0;
   int src_bit[13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

   always #2.5 clk = ~clk;

   irq_event_distributor u_irq_event_distributor (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_line(irq_line)
   );

   function automatic logic [12:0] pick(input logic [31:0] v);
      logic [12:0] r;
      for (int i = 0; i < 13; i++) r[i] = v[src_bit[i]];
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [12:0] p, input logic w, input logic [1:0] a,
                       input logic [31:0] d, input string tag);
      logic [31:0] setv, clrv, rexp;
      logic [12:0] lexp;
      @(negedge clk);
      evt_pulse = p; reg_wr = w; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      lexp = pick(cause_m & mask_m);
      setv = '0;
      for (int i = 0; i < 13; i++) if (p[i]) setv[src_bit[i]] = 1'b1;
      if (w && a == 2'd2) setv[23] = 1'b1;
      if (w && a == 2'd3 && d[0]) setv[28] = 1'b1;
      clrv = (w && a == 2'd0) ? d : '0;
      cause_m = (cause_m & ~clrv) | setv;
      if (w && a == 2'd1) mask_m = d;
      rexp = (a == 2'd0) ? cause_m : (a == 2'd1) ? mask_m : '0;
      check(tag, reg_rdata, rexp);
      check("R2 lines", {19'd0, irq_line}, {19'd0, lexp});
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED1234));
      // R8: reset state
      reg_addr = 2'd0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R8 cause", reg_rdata, '0);
      check("R8 lines", {19'd0, irq_line}, '0);
      reg_addr = 2'd1; #1;
      check("R8 mask", reg_rdata, '0);
      rst_n = 1'b1;

      step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R4");
      for (int i = 0; i < 13; i++) step(13'd1 << i, 1'b0, 2'd0, '0, "R1");
      step('0, 1'b0, 2'd0, '0, "R1");
      step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R3");
      step('0, 1'b0, 2'd0, '0, "R3");
      step(13'h010, 1'b1, 2'd0, 32'hFFFF_FFFF, "R7");
      step('0, 1'b1, 2'd0, 32'h0200_0000, "R3");
      step('0, 1'b1, 2'd3, 32'h0000_0000, "R6");
      step('0, 1'b0, 2'd0, '0, "R6");
      step('0, 1'b1, 2'd3, 32'h0000_0001, "R6");
      step('0, 1'b1, 2'd2, 32'h0000_0000, "R5");
      step('0, 1'b0, 2'd0, '0, "R5");
      step('0, 1'b0, 2'd2, '0, "R9");
      step('0, 1'b0, 2'd3, '0, "R9");
      step('0, 1'b1, 2'd1, 32'h0000_0000, "R4");
      step('0, 1'b0, 2'd0, '0, "R2");

      for (int k = 0; k < 600; k++) begin
         logic [1:0] a;
         logic [12:0] p;
         string tag;
         a = 2'($urandom);
         p = 13'($urandom & $urandom & $urandom);
         tag = (a == 2'd0) ? "R3" : (a == 2'd1) ? "R4" : (a == 2'd2) ? "R5" : "R6";
         step(p, 1'($urandom), a, $urandom, tag);
      end
      step('0, 1'b0, 2'd0, '0, "R3");
      step('0, 1'b0, 2'd0, '0, "R2");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule